// File: doc/BRIEF.md
# Two-Level Channel Interrupt Aggregator

This block gathers interrupt events from a set of host channels and turns them into one interrupt line. Each channel owns a status register and a mask register with one bit per cause. A channel with any unmasked pending cause raises its bit in a read-only channel summary. The summary has its own mask, and the masked summary feeds one fixed bit of a top-level status register. The other top-level bits latch their own event pulses. The masked top-level status, gated by a global enable, drives a registered level interrupt.

Status bits record every event whatever the masks say, so software can always poll. Leaf bits clear when software writes 1 to them. The summary bits and the channel bit at the top cannot be written. They fall only once the causing channel bits have been cleared, or masked at the channel.

The register port is a plain write strobe with an address and write data, plus a combinational read of the addressed register. Register map (word addresses): 0 top status, 1 top mask, 2 global enable (bit 0), 3 channel summary, 4 summary mask, 8+2c status of channel c, 9+2c mask of channel c.

Top module: `irq_status_aggregator`

## Requirements
- R1: After reset every status, mask and enable register reads 0 and `irq` is low.
- R2: A pulse on `chan_evt[c*NUM_CAUSE+k]` sets bit k of channel c status (address 8+2c) whatever any mask holds.
- R3: Writing 1 to a channel status bit clears it, writing 0 leaves it unchanged, and a status bit never falls without a write.
- R4: Summary bit c (address 3) is 1 exactly when channel c has a status bit whose mask bit (address 9+2c, 1 = unmasked) is 1; writes to address 3 have no effect.
- R5: Top status bit HOST_BIT is the OR of the summary ANDed with the summary mask (address 4, 1 = unmasked); it ignores writes and `top_evt` at that position.
- R6: Every other top status bit b is set by a pulse on `top_evt[b]` and cleared by writing 1 to it at address 0.
- R7: `irq` is a registered level: it is high in the cycle after the top status ANDed with the top mask (address 1, 1 = unmasked) is nonzero while the global enable is 1, and stays high while that holds.
- R8: With the global enable at 0 `irq` stays low while all status registers keep recording events.
- R9: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| chan_evt | input | NUM_CH*NUM_CAUSE | Per-channel cause event pulses |
| top_evt | input | NUM_TOP | Top-level cause event pulses |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds the block with 16 channels of 4 causes, 8 top-level causes and the channel roll-up at top bit 2. The full channel count puts channel 15 and the top bit of the summary in reach, so the upper boundary of the summary mask is checked. A small cause count keeps the flat event vector short while the channel and global mask gating, the roll-up on the fixed top bit, and the same-cycle set-and-clear race are all exercised.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned ADR_TOP_STS = 0;
    localparam int unsigned ADR_TOP_MSK = 1;
    localparam int unsigned ADR_GLB_EN  = 2;
    localparam int unsigned ADR_SUM     = 3;
    localparam int unsigned ADR_SUM_MSK = 4;
    localparam int unsigned ADR_CH_BASE = 8;

    typedef struct packed {
        logic top_sts;
        logic top_msk;
        logic glb_en;
        logic sum_msk;
    } glb_wr_t;

    function automatic int unsigned ch_sts_adr(input int unsigned c);
        return ADR_CH_BASE + 2 * c;
    endfunction

    function automatic int unsigned ch_msk_adr(input int unsigned c);
        return ADR_CH_BASE + 2 * c + 1;
    endfunction

endpackage

// File: rtl/irq_chan_regs.sv
module irq_chan_regs #(
    parameter int NUM_CAUSE = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sts_wr,
    input  logic                 msk_wr,
    input  logic [NUM_CAUSE-1:0] wdata,
    input  logic [NUM_CAUSE-1:0] evt,
    output logic [NUM_CAUSE-1:0] sts,
    output logic [NUM_CAUSE-1:0] msk,
    output logic                 pend
);
    logic [NUM_CAUSE-1:0] clr;

    always_comb clr = sts_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            msk <= '0;
        end else begin
            sts <= (sts & ~clr) | evt;
            if (msk_wr) msk <= wdata;
        end
    end

    always_comb pend = |(sts & msk);
endmodule

// File: rtl/irq_top_regs.sv
module irq_top_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int NUM_TOP  = 8,
    parameter int HOST_BIT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  glb_wr_t            wr,
    input  logic [NUM_TOP-1:0] wdata_top,
    input  logic [NUM_CH-1:0]  wdata_sum,
    input  logic               wdata_en,
    input  logic [NUM_TOP-1:0] top_evt,
    input  logic [NUM_CH-1:0]  summary,
    output logic [NUM_TOP-1:0] top_sts,
    output logic [NUM_TOP-1:0] top_msk,
    output logic [NUM_CH-1:0]  sum_msk,
    output logic               glb_en,
    output logic               irq
);
    for (genvar b = 0; b < NUM_TOP; b++) begin : g_bit
        if (b == HOST_BIT) begin : g_host
            always_comb top_sts[b] = |(summary & sum_msk);
        end else begin : g_leaf
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= (q & ~(wr.top_sts & wdata_top[b])) | top_evt[b];
            end
            always_comb top_sts[b] = q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_msk <= '0;
            sum_msk <= '0;
            glb_en  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (wr.top_msk) top_msk <= wdata_top;
            if (wr.sum_msk) sum_msk <= wdata_sum;
            if (wr.glb_en)  glb_en  <= wdata_en;
            irq <= glb_en & |(top_sts & top_msk);
        end
    end
endmodule

// File: rtl/irq_status_aggregator.sv
module irq_status_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_CAUSE = 8,
    parameter int NUM_TOP   = 8,
    parameter int HOST_BIT  = 2,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [NUM_CH*NUM_CAUSE-1:0] chan_evt,
    input  logic [NUM_TOP-1:0]          top_evt,
    output logic                        irq
);
    localparam int EVT_W = NUM_CH * NUM_CAUSE;

    logic [NUM_CAUSE-1:0] ch_sts [NUM_CH];
    logic [NUM_CAUSE-1:0] ch_msk [NUM_CH];
    logic [EVT_W-1:0]     chan_sts_flat;
    logic [NUM_CH-1:0]    summary;
    logic [NUM_TOP-1:0]   top_sts;
    logic [NUM_TOP-1:0]   top_msk;
    logic [NUM_CH-1:0]    sum_msk;
    logic                 glb_en;
    glb_wr_t              gwr;

    always_comb begin
        gwr.top_sts = reg_wr && (reg_addr == ADDR_W'(ADR_TOP_STS));
        gwr.top_msk = reg_wr && (reg_addr == ADDR_W'(ADR_TOP_MSK));
        gwr.glb_en  = reg_wr && (reg_addr == ADDR_W'(ADR_GLB_EN));
        gwr.sum_msk = reg_wr && (reg_addr == ADDR_W'(ADR_SUM_MSK));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sts_wr, msk_wr;
        always_comb begin
            sts_wr = reg_wr && (reg_addr == ADDR_W'(ch_sts_adr(c)));
            msk_wr = reg_wr && (reg_addr == ADDR_W'(ch_msk_adr(c)));
        end
        irq_chan_regs #(.NUM_CAUSE(NUM_CAUSE)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .sts_wr(sts_wr),
            .msk_wr(msk_wr),
            .wdata (reg_wdata[NUM_CAUSE-1:0]),
            .evt   (chan_evt[c*NUM_CAUSE +: NUM_CAUSE]),
            .sts   (ch_sts[c]),
            .msk   (ch_msk[c]),
            .pend  (summary[c])
        );
        always_comb chan_sts_flat[c*NUM_CAUSE +: NUM_CAUSE] = ch_sts[c];
    end

    irq_top_regs #(.NUM_CH(NUM_CH), .NUM_TOP(NUM_TOP), .HOST_BIT(HOST_BIT)) u_top (
        .clk      (clk),
        .rst      (rst),
        .wr       (gwr),
        .wdata_top(reg_wdata[NUM_TOP-1:0]),
        .wdata_sum(reg_wdata[NUM_CH-1:0]),
        .wdata_en (reg_wdata[0]),
        .top_evt  (top_evt),
        .summary  (summary),
        .top_sts  (top_sts),
        .top_msk  (top_msk),
        .sum_msk  (sum_msk),
        .glb_en   (glb_en),
        .irq      (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADR_TOP_STS)) reg_rdata = DATA_W'(top_sts);
        if (reg_addr == ADDR_W'(ADR_TOP_MSK)) reg_rdata = DATA_W'(top_msk);
        if (reg_addr == ADDR_W'(ADR_GLB_EN))  reg_rdata = DATA_W'(glb_en);
        if (reg_addr == ADDR_W'(ADR_SUM))     reg_rdata = DATA_W'(summary);
        if (reg_addr == ADDR_W'(ADR_SUM_MSK)) reg_rdata = DATA_W'(sum_msk);
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(ch_sts_adr(c))) reg_rdata = DATA_W'(ch_sts[c]);
            if (reg_addr == ADDR_W'(ch_msk_adr(c))) reg_rdata = DATA_W'(ch_msk[c]);
        end
    end
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int NUM_CH    = 16,
    parameter int NUM_CAUSE = 8,
    parameter int NUM_TOP   = 8,
    parameter int HOST_BIT  = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        reg_wr,
    input logic [NUM_CH*NUM_CAUSE-1:0] chan_evt,
    input logic [NUM_CH*NUM_CAUSE-1:0] chan_sts_flat,
    input logic [NUM_CH-1:0]           summary,
    input logic [NUM_TOP-1:0]          top_sts,
    input logic                        glb_en,
    input logic                        irq
);
    // R2 and R9: every pulsed cause is set one cycle later, clear or not
    a_r2_evt_sets_status: assert property (@(posedge clk) disable iff (rst)
        (chan_evt != '0) |=> ((chan_sts_flat & $past(chan_evt)) == $past(chan_evt)));

    // R3: without a write no channel status bit falls
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> (($past(chan_sts_flat) & ~chan_sts_flat) == '0));

    // R4: a summary bit needs some pending channel status
    a_r4_summary_has_source: assert property (@(posedge clk) disable iff (rst)
        (summary != '0) |-> (chan_sts_flat != '0));

    // R5: the roll-up bit is low whenever the summary is empty
    a_r5_host_bit_follows: assert property (@(posedge clk) disable iff (rst)
        (summary == '0) |-> !top_sts[HOST_BIT]);

    // R7: the line rises only on a cause present in the previous cycle
    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(top_sts) != '0));

    // R8: a disabled line is low in the following cycle
    a_r8_gate_off: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> !irq);
endmodule

bind irq_status_aggregator irq_agg_checker #(
    .NUM_CH(NUM_CH), .NUM_CAUSE(NUM_CAUSE), .NUM_TOP(NUM_TOP), .HOST_BIT(HOST_BIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .chan_evt     (chan_evt),
    .chan_sts_flat(chan_sts_flat),
    .summary      (summary),
    .top_sts      (top_sts),
    .glb_en       (glb_en),
    .irq          (irq)
);

// File: tb/irq_status_aggregator_bench.sv
module irq_status_aggregator_bench;
    localparam int NUM_CH = 16, NUM_CAUSE = 4, NUM_TOP = 8, HOST_BIT = 2;
    localparam int DATA_W = 16, ADDR_W = 6;
    localparam int EVT_W = NUM_CH * NUM_CAUSE;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [EVT_W-1:0]  chan_evt = '0;
    logic [NUM_TOP-1:0] top_evt = '0;
    logic              irq;

    always #10 clk = ~clk;

    irq_status_aggregator #(
        .NUM_CH(NUM_CH), .NUM_CAUSE(NUM_CAUSE), .NUM_TOP(NUM_TOP),
        .HOST_BIT(HOST_BIT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_irq_status_aggregator (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_evt(chan_evt), .top_evt(top_evt), .irq(irq)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] exp_rd;
        logic              exp_irq;
        string             tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Driver side: addresses a register and queues what must be seen
    task automatic expect_rd(input int addr, input int exp_rd, input bit exp_irq, input string tag);
        item_t it;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_addr = ADDR_W'(addr);
        #2;
        it.addr = ADDR_W'(addr);
        it.exp_rd = DATA_W'(exp_rd);
        it.exp_irq = exp_irq;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = ADDR_W'(addr);
        reg_wdata = DATA_W'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_ch(input int bit_idx);
        @(negedge clk);
        chan_evt[bit_idx] = 1'b1;
        @(negedge clk);
        chan_evt = '0;
    endtask

    task automatic pulse_top(input int bit_idx);
        @(negedge clk);
        top_evt[bit_idx] = 1'b1;
        @(negedge clk);
        top_evt = '0;
    endtask

    task automatic clr_and_evt(input int addr, input int data, input int bit_idx);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = ADDR_W'(addr);
        reg_wdata = DATA_W'(data);
        chan_evt[bit_idx] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chan_evt = '0;
    endtask

    // Monitor side: pops and compares
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            checks++;
            if (reg_rdata !== it.exp_rd || irq !== it.exp_irq) begin
                errors++;
                $display("FAIL %s addr=%0d actual rd=%h irq=%b expected rd=%h irq=%b",
                         it.tag, it.addr, reg_rdata, irq, it.exp_rd, it.exp_irq);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_rd(0, 0, 0, "R1 top status");
        expect_rd(3, 0, 0, "R1 summary");
        expect_rd(2, 0, 0, "R1 global enable");
        expect_rd(9, 0, 0, "R1 channel 0 mask");
        // R2 event recorded while everything is masked
        pulse_ch(1);
        expect_rd(8, 'h2, 0, "R2 channel 0 status");
        expect_rd(3, 0, 0, "R4 summary masked");
        wr(9, 'h2);
        expect_rd(3, 'h1, 0, "R4 summary unmasked");
        expect_rd(0, 0, 0, "R5 roll-up masked");
        wr(4, 'h1);
        expect_rd(0, 'h4, 0, "R5 roll-up set");
        wr(1, 'h4);
        expect_rd(0, 'h4, 0, "R8 enable off irq low");
        wr(2, 1);
        expect_rd(0, 'h4, 1, "R7 irq level");
        expect_rd(0, 'h4, 1, "R7 irq stays high");
        // R5 roll-up bit and R4 summary are not writable
        wr(0, 'h4);
        expect_rd(0, 'h4, 1, "R5 write ignored");
        wr(3, 'hFFFF);
        expect_rd(3, 'h1, 1, "R4 write ignored");
        // R3 write 0 no effect, write 1 clears
        wr(8, 0);
        expect_rd(8, 'h2, 1, "R3 write zero");
        wr(8, 'h2);
        expect_rd(8, 0, 0, "R3 write one clears");
        expect_rd(3, 0, 0, "R4 summary falls");
        expect_rd(0, 0, 0, "R5 roll-up falls");
        // Channel 15 at the top of the summary
        pulse_ch(63);
        wr(39, 'h8);
        wr(4, 'h8001);
        expect_rd(3, 'h8000, 1, "R4 channel 15 summary");
        wr(39, 0);
        expect_rd(3, 0, 0, "R4 channel mask drops summary");
        expect_rd(38, 'h8, 0, "R2 channel 15 status kept");
        wr(38, 'h8);
        expect_rd(38, 0, 0, "R3 channel 15 cleared");
        // R6 top-level leaf cause
        pulse_top(7);
        expect_rd(0, 'h80, 0, "R6 top cause masked");
        wr(1, 'h84);
        expect_rd(0, 'h80, 1, "R7 top cause unmasked");
        wr(2, 0);
        pulse_top(5);
        expect_rd(0, 'hA0, 0, "R8 status updates while disabled");
        wr(2, 1);
        wr(0, 'hA0);
        expect_rd(0, 0, 0, "R6 top cause cleared");
        // R5 event on the roll-up position ignored
        pulse_top(HOST_BIT);
        expect_rd(0, 0, 0, "R5 top event on roll-up ignored");
        // R9 set wins over clear in the same cycle
        pulse_ch(12);
        expect_rd(14, 'h1, 0, "R2 channel 3 status");
        clr_and_evt(14, 'h1, 12);
        expect_rd(14, 'h1, 0, "R9 set wins");
        wr(14, 'h1);
        expect_rd(14, 0, 0, "R3 channel 3 cleared");
        wait (sb_q.size() == 0);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule